// File: doc/BRIEF.md
# Compute Mode Request Handshake

This block holds a small control register through which software asks the processor subsystem to enter a compute-only operating mode and later to leave it. Software sets a request bit to ask for entry and clears it to ask for exit. A four-state sequencer turns that bit into a level request toward a downstream quiesce agent. The agent raises its done line when entry has finished and lowers it again when exit has finished. A read-only acknowledge bit shows software whether the mode is in force. It stays set for the whole exit phase and drops only once exit has finished.

A second register bit enables wake-on-interrupt. While it is set, any interrupt or exception vector fetch, seen as a one-cycle strobe, clears the request bit in hardware. The sequencer then leaves compute mode without software having to act. The bit positions of the three fields, the register width and an optional synchronizer depth on the done input are parameters. The gating of clocks or power is the partner's business and is outside this block.

Top module: `cpm_handshake`

## Requirements
- R1: While reset is asserted and after it is released, the read data is all zero and the downstream request is low. This holds even when reset arrives in the middle of compute mode.
- R2: A register write stores write-data bit 0 as the request bit. Bit 0 of the read data returns it. Writing bit 1 has no effect, and every read-data bit other than 0, 1 and 2 reads 0.
- R3: A register write stores write-data bit 2 as the wake-on-interrupt enable, and bit 2 of the read data returns it.
- R4: When the sequencer is idle and the request bit is 1, the downstream request goes high on the next clock edge.
- R5: The acknowledge (read-data bit 1) stays 0 while entry is in progress. It goes to 1 on the clock edge at which the done input is seen high.
- R6: When the request bit is cleared after entry has finished, the downstream request drops on the following edge while the acknowledge stays 1. The acknowledge falls on the edge at which done is seen low.
- R7: If the request bit is cleared while entry is in progress, the downstream request stays high until done is seen high. The sequencer then goes straight to the exit phase: the acknowledge rises and the downstream request falls on that same edge.
- R8: With the wake-on-interrupt enable at 1, a vector-fetch strobe clears the request bit on the next edge and leaves the enable unchanged.
- R9: With the wake-on-interrupt enable at 0, a vector-fetch strobe leaves the request bit unchanged.
- R10: If a write of request 1 and a vector fetch fall in the same cycle while the enable is 1, the hardware clear wins and the request bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (request, acknowledge, wake enable) |
| vec_fetch | input | 1 | One-cycle strobe for an interrupt or exception vector fetch |
| quiesce_req | output | 1 | Level request toward the quiesce agent |
| quiesce_done | input | 1 | Agent's indication: high once entry has finished, low once exit has finished |

## Verification
Two functions can fall in the same cycle: a software write that sets the request bit, and a vector fetch that clears it through the wake-on-interrupt path. The bench first sets the enable, then issues one cycle that carries both the write strobe with request 1 and the fetch strobe. On the next edge it expects the request bit at 0, the enable still at 1 and the downstream request still low. A second collision, between a request clear and the agent's entry-done, is provoked during the entry phase. It is judged by the acknowledge rising at the same edge as the downstream request falls.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
   typedef enum logic [1:0] {
      CPM_IDLE   = 2'd0,
      CPM_ENTER  = 2'd1,
      CPM_ACTIVE = 2'd2,
      CPM_EXIT   = 2'd3
   } cpm_state_e;
endpackage

// File: rtl/cpm_sync.sv
module cpm_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2+((STAGES>1)?0:1):0], din};
         end
         assign dout = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cpm_ctrl_reg.sv
module cpm_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_req,
   input  logic wr_woi,
   input  logic vec_fetch,
   output logic req_q,
   output logic woi_q
);
   logic hw_clear;
   assign hw_clear = woi_q & vec_fetch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         woi_q <= 1'b0;
      end else begin
         if (hw_clear)   req_q <= 1'b0;
         else if (wr_en) req_q <= wr_req;
         if (wr_en)      woi_q <= wr_woi;
      end
   end
endmodule

// File: rtl/cpm_seq.sv
module cpm_seq
   import cpm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic done,
   output logic qreq,
   output logic ack
);
   cpm_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CPM_IDLE:   if (req)  st_d = CPM_ENTER;
         CPM_ENTER:  if (done) st_d = req ? CPM_ACTIVE : CPM_EXIT;
         CPM_ACTIVE: if (!req) st_d = CPM_EXIT;
         CPM_EXIT:   if (!done) st_d = CPM_IDLE;
         default:    st_d = CPM_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= CPM_IDLE;
      else        st_q <= st_d;
   end

   assign qreq = (st_q == CPM_ENTER) || (st_q == CPM_ACTIVE);
   assign ack  = (st_q == CPM_ACTIVE) || (st_q == CPM_EXIT);
endmodule

// File: rtl/cpm_handshake.sv
module cpm_handshake #(
   parameter int REG_W       = 32,
   parameter int REQ_POS     = 0,
   parameter int ACK_POS     = 1,
   parameter int WOI_POS     = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             vec_fetch,
   output logic             quiesce_req,
   input  logic             quiesce_done
);
   generate
      if (REG_W < 3) begin : g_bad_width
         $error("register width must hold three fields");
      end
      if (REQ_POS >= REG_W || ACK_POS >= REG_W || WOI_POS >= REG_W) begin : g_bad_pos
         $error("field position outside register");
      end
      if (REQ_POS == ACK_POS || REQ_POS == WOI_POS || ACK_POS == WOI_POS) begin : g_overlap
         $error("field positions overlap");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("synchronizer depth out of range");
      end
   endgenerate

   logic req_q, woi_q, ack, done_s;
   logic unused_wbits;
   assign unused_wbits = ^reg_wdata;

   cpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (quiesce_done),
      .dout (done_s)
   );

   cpm_ctrl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_req   (reg_wdata[REQ_POS]),
      .wr_woi   (reg_wdata[WOI_POS]),
      .vec_fetch(vec_fetch),
      .req_q    (req_q),
      .woi_q    (woi_q)
   );

   cpm_seq u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_q),
      .done (done_s),
      .qreq (quiesce_req),
      .ack  (ack)
   );

   always_comb begin
      reg_rdata          = '0;
      reg_rdata[REQ_POS] = req_q;
      reg_rdata[ACK_POS] = ack;
      reg_rdata[WOI_POS] = woi_q;
   end
endmodule

// File: rtl/cpm_handshake_chk.sv
module cpm_handshake_chk #(
   parameter int REG_W   = 32,
   parameter int REQ_POS = 0,
   parameter int ACK_POS = 1,
   parameter int WOI_POS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic             vec_fetch,
   input logic             quiesce_req,
   input logic             quiesce_done,
   input logic [REG_W-1:0] reg_rdata
);
   localparam logic [REG_W-1:0] ONE  = 1;
   localparam logic [REG_W-1:0] KEEP = (ONE << REQ_POS) | (ONE << ACK_POS) | (ONE << WOI_POS);

   logic req, ack, woi;
   assign req = reg_rdata[REQ_POS];
   assign ack = reg_rdata[ACK_POS];
   assign woi = reg_rdata[WOI_POS];

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~KEEP) == '0);

   assert_enter_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && !quiesce_req && req) |=> quiesce_req);

   assert_ack_rise_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(quiesce_done));

   assert_ack_fall_on_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> !$past(quiesce_done));

   assert_exit_keeps_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(quiesce_req) |-> ack);

   assert_fetch_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (woi && vec_fetch) |=> (!req && woi));

   assert_fetch_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!woi && vec_fetch && !reg_wr_en) |=> $stable(req));
endmodule

bind cpm_handshake cpm_handshake_chk #(
   .REG_W  (REG_W),
   .REQ_POS(REQ_POS),
   .ACK_POS(ACK_POS),
   .WOI_POS(WOI_POS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .vec_fetch   (vec_fetch),
   .quiesce_req (quiesce_req),
   .quiesce_done(quiesce_done),
   .reg_rdata   (reg_rdata)
);

// File: tb/tb_cpm_handshake.sv
module tb_cpm_handshake;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        vec_fetch = 1'b0;
   logic        quiesce_req;
   logic        quiesce_done = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   cpm_handshake dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .vec_fetch   (vec_fetch),
      .quiesce_req (quiesce_req),
      .quiesce_done(quiesce_done)
   );

   // fields: [9] write, [8:6] wdata {woi,ack,req}, [5] fetch, [4] done,
   //         [3:1] expected read {woi,ack,req}, [0] expected downstream request
   localparam int NV = 18;
   localparam logic [9:0] VEC [NV] = '{
      10'b1_001_0_0_001_0, // R4: set request
      10'b0_000_0_0_001_1, // R4: entry begins
      10'b0_000_0_0_001_1, // R5: ack low while entering
      10'b0_000_0_1_011_1, // R5: done seen, ack high
      10'b0_000_0_1_011_1,
      10'b1_000_0_1_010_1, // R6: clear request
      10'b0_000_0_1_010_0, // R6: exit, ack held
      10'b0_000_0_1_010_0,
      10'b0_000_0_0_000_0, // R6: done low, ack drops
      10'b0_000_0_0_000_0,
      10'b1_001_0_0_001_0, // R7: set again
      10'b0_000_0_0_001_1,
      10'b1_000_0_0_000_1, // R7: clear while entering
      10'b0_000_0_0_000_1, // R7: request held high
      10'b0_000_0_1_010_0, // R7: straight to exit
      10'b0_000_0_1_010_0,
      10'b0_000_0_0_000_0,
      10'b0_000_0_0_000_0
   };

   task automatic check(input string tag, input logic [31:0] exp_rd, input logic exp_q);
      checks++;
      if (reg_rdata !== exp_rd || quiesce_req !== exp_q) begin
         errors++;
         $display("FAIL %s rdata=%h req=%b expected rdata=%h req=%b",
                  tag, reg_rdata, quiesce_req, exp_rd, exp_q);
      end
   endtask

   task automatic step(input logic we, input logic [31:0] wd, input logic vf, input logic dn);
      reg_wr_en = we; reg_wdata = wd; vec_fetch = vf; quiesce_done = dn;
      @(posedge clk); #2;
   endtask

   task automatic apply_reset();
      reg_wr_en = 1'b0; reg_wdata = '0; vec_fetch = 1'b0; quiesce_done = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      check("R1 in reset", 32'h0, 1'b0);
      rst_n = 1'b1;
   endtask

   initial begin
      apply_reset();
      step(0, 0, 0, 0);
      check("R1 after release", 32'h0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [9:0] v;
         v = VEC[i];
         step(v[9], {29'b0, v[8:6]}, v[5], v[4]);
         check($sformatf("R4/R5/R6/R7 vector %0d", i), {29'b0, v[3:1]}, v[0]);
      end

      // R2: all ones written, only request and enable land
      apply_reset();
      step(1, 32'hFFFF_FFFF, 0, 0);
      check("R2 write all ones", 32'h5, 1'b0);

      // R1: reset from compute mode
      apply_reset();
      step(1, 32'h1, 0, 0);
      step(0, 0, 0, 0);
      step(0, 0, 0, 1);
      check("R1 reached active", 32'h3, 1'b1);
      apply_reset();
      step(0, 0, 0, 0);
      check("R1 reset from active", 32'h0, 1'b0);

      // R3: enable written and cleared
      step(1, 32'h4, 0, 0);
      check("R3 enable set", 32'h4, 1'b0);
      step(1, 32'h0, 0, 0);
      check("R3 enable cleared", 32'h0, 1'b0);

      // R9: fetch with enable clear
      apply_reset();
      step(1, 32'h1, 0, 0);
      step(0, 0, 1, 0);
      check("R9 fetch ignored", 32'h1, 1'b1);

      // R8: fetch with enable set
      apply_reset();
      step(1, 32'h5, 0, 0);
      check("R8 armed", 32'h5, 1'b0);
      step(0, 0, 1, 0);
      check("R8 fetch clears request", 32'h4, 1'b1);
      step(0, 0, 0, 1);
      check("R8 exit after wake", 32'h6, 1'b0);
      step(0, 0, 0, 0);
      check("R8 back to idle", 32'h4, 1'b0);

      // R10: write and fetch in the same cycle
      apply_reset();
      step(1, 32'h4, 0, 0);
      step(1, 32'h5, 1, 0);
      check("R10 clear wins", 32'h4, 1'b0);
      step(0, 0, 0, 0);
      check("R10 no entry", 32'h4, 1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule